// File: doc/BRIEF.md
# SPI Calendar Clock Slave

This block is a real-time clock that a host reaches over a four-wire serial link in mode 3: the clock line idles high, the slave samples the data input on rising edges and changes its data output on falling edges. It holds seconds, minutes, hours, weekday, day of month, month and a two-digit year as BCD bytes. A one-cycle pulse on `sec_tick` advances that time by one second. All link pins are oversampled in the system clock domain, so the system clock must run well above the link clock. The bench runs a 125 MHz system clock against a link clock of about 1 MHz.

Each chip-select period starts with a command byte. Its most significant bit picks the direction: 1 means write and 0 means read. The lower seven bits give a register address. A write stores each following byte at the current address and then steps the address by one, so one eight-byte burst can load the whole time and date. A read returns the addressed register in the byte that follows the command. Two bits can freeze the clock. One is a stop bit in the seconds register. The other is a hold flag in a control register, which reset sets and the host clears. A century-enable bit and a century bit share the hours register with the hour value. The century bit flips each time the year rolls over, but only while century-enable is set.

Top module: `serial_rtc_slave`

## Requirements
- R1: After reset the registers read as follows: seconds 0x00 (stop clear), minutes 0x00, hours 0x00, weekday 0x01, day 0x01, month 0x01, year 0x00. The control register at address 0x0C reads 0x40, meaning the hold flag (bit 6) is set.
- R2: A command byte with bit 7 = 1 starts a write at the address in bits 6:0. Each further byte in the same chip-select period is stored at the current address, which then steps by one. Addresses 0x01 to 0x07 hold seconds, minutes, hours, weekday, day, month and year. At 0x0C only bit 6 is stored.
- R3: A command byte with bit 7 = 0 starts a read. During the next byte the slave drives the addressed register on `spi_miso`, most significant bit first. Each bit changes on a falling clock edge and is valid at the following rising edge.
- R4: While `spi_cs_n` is high, `spi_miso` is driven low.
- R5: A tick advances the seconds in BCD when the stop bit (seconds bit 7) and the hold flag are both clear. For example, 0x09 becomes 0x10, and 0x59 becomes 0x00 with a carry into the minutes.
- R6: The carries form a chain. Minutes roll over at 59 and hours at 23 (24-hour, hours bits 5:0). Weekday steps from 7 back to 1. Day, month and year roll over at their ends: day 31 of month 12 in year 99 becomes day 01, month 01, year 00.
- R7: Month lengths are 31 days, or 30 for months 04, 06, 09 and 11. February has 29 days when the BCD year is a multiple of four (00 counts) and 28 days otherwise.
- R8: When the year rolls over from 99 to 00, the century bit (hours bit 6) toggles if century-enable (hours bit 7) is set. Otherwise both bits stay unchanged.
- R9: While the stop bit is set, ticks change no register. Writing the seconds register with bit 7 at 0 lets counting resume.
- R10: While the hold flag is set, ticks change no register. Writing 0x00 to address 0x0C clears the flag.
- R11: A tick that arrives while `spi_cs_n` is low is deferred. It is applied once, after chip select is released. Several ticks arriving during one transfer add only one second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run well above the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse, one per second |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host; low while deselected |

## Verification
A wrong shift count or address pointer shows up in the very next byte the host reads back. It appears as a misaligned value or as data from the wrong register, so it is caught within one read transfer. A fault in the carry chain or the month-length logic stays hidden until a tick has been applied and the affected field has been read. The bench therefore positions the time just before each rollover, ticks once, and reads every field involved. A faulty stop, hold or deferral path shows up as a seconds value that moved too far, or did not move, by the next read.

// File: rtl/serial_rtc_pkg.sv
package serial_rtc_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 7;
    localparam int STOP_BIT = 7;   // seconds register
    localparam int CEN_BIT  = 7;   // hours register: century enable
    localparam int CENT_BIT = 6;   // hours register: century
    localparam int HOLD_BIT = 6;   // control register

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_SEC  = 7'h01,
        RA_MIN  = 7'h02,
        RA_HOUR = 7'h03,
        RA_WDAY = 7'h04,
        RA_DATE = 7'h05,
        RA_MON  = 7'h06,
        RA_YEAR = 7'h07,
        RA_CTRL = 7'h0C
    } reg_addr_e;

    typedef struct packed {
        byte_t sec;
        byte_t min;
        byte_t hour;
        byte_t wday;
        byte_t date;
        byte_t mon;
        byte_t year;
    } cal_t;

    localparam cal_t CAL_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                   wday: 8'h01, date: 8'h01, mon: 8'h01,
                                   year: 8'h00};

    // Two-digit BCD increment (no wrap handling; callers compare first).
    function automatic byte_t bcd_inc(input byte_t v);
        if (v[3:0] >= 4'h9)
            return {v[7:4] + 4'h1, 4'h0};
        return v + 8'h01;
    endfunction

    // BCD year divisible by four: even tens need units 0/4/8, odd tens 2/6.
    function automatic logic bcd_leap(input byte_t y);
        if (y[4])
            return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
        return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
    endfunction

    function automatic byte_t bcd_month_len(input byte_t m, input byte_t y);
        case (m)
            8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/serial_rtc_link.sv
module serial_rtc_link
    import serial_rtc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sclk,
    input  logic  cs_n,
    input  logic  mosi,
    input  logic  tx_load,
    input  byte_t tx_data,
    output logic  cs_active,
    output logic  rx_valid,
    output logic  rx_first,
    output byte_t rx_byte,
    output logic  miso
);

    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    logic [1:0]       sclk_s, cs_s, mosi_s;
    logic             sclk_d;
    logic [BIT_W-1:0] bit_q;
    byte_t            shift_q, tx_q;
    logic             first_q, load_pend_q;
    logic             sclk_rise, sclk_fall;

    assign cs_active = ~cs_s[1];
    assign sclk_rise = sclk_s[1] & ~sclk_d;
    assign sclk_fall = ~sclk_s[1] & sclk_d;
    assign miso      = cs_active & tx_q[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_s      <= 2'b11;
            cs_s        <= 2'b11;
            mosi_s      <= 2'b00;
            sclk_d      <= 1'b1;
            bit_q       <= '0;
            shift_q     <= '0;
            tx_q        <= '0;
            first_q     <= 1'b1;
            load_pend_q <= 1'b0;
            rx_valid    <= 1'b0;
            rx_first    <= 1'b0;
            rx_byte     <= '0;
        end else begin
            sclk_s   <= {sclk_s[0], sclk};
            cs_s     <= {cs_s[0], cs_n};
            mosi_s   <= {mosi_s[0], mosi};
            sclk_d   <= sclk_s[1];
            rx_valid <= 1'b0;
            if (!cs_active) begin
                bit_q       <= '0;
                first_q     <= 1'b1;
                tx_q        <= '0;
                load_pend_q <= 1'b0;
            end else begin
                if (sclk_rise) begin
                    shift_q <= {shift_q[BYTE_W-2:0], mosi_s[1]};
                    bit_q   <= bit_q + BIT_W'(1);
                    if (bit_q == LAST_BIT) begin
                        rx_valid <= 1'b1;
                        rx_byte  <= {shift_q[BYTE_W-2:0], mosi_s[1]};
                        rx_first <= first_q;
                        first_q  <= 1'b0;
                    end
                end
                if (tx_load)
                    load_pend_q <= 1'b1;
                if (sclk_fall) begin
                    if (load_pend_q) begin
                        tx_q        <= tx_data;
                        load_pend_q <= 1'b0;
                    end else begin
                        tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

endmodule

// File: rtl/serial_rtc_advance.sv
module serial_rtc_advance
    import serial_rtc_pkg::*;
(
    input  cal_t cur,
    output cal_t nxt
);

    logic  wrap_s, wrap_m, wrap_h, wrap_d, wrap_mo, wrap_y;
    byte_t sec_v, hour_v, mlen;

    always_comb begin
        sec_v  = {1'b0, cur.sec[BYTE_W-2:0]};
        hour_v = {2'b00, cur.hour[5:0]};
        mlen   = bcd_month_len(cur.mon, cur.year);

        wrap_s  = (sec_v == 8'h59);
        wrap_m  = wrap_s && (cur.min == 8'h59);
        wrap_h  = wrap_m && (hour_v == 8'h23);
        wrap_d  = wrap_h && (cur.date == mlen);
        wrap_mo = wrap_d && (cur.mon == 8'h12);
        wrap_y  = wrap_mo && (cur.year == 8'h99);

        nxt = cur;
        nxt.sec = wrap_s ? 8'h00 : bcd_inc(sec_v);
        if (wrap_s)
            nxt.min = wrap_m ? 8'h00 : bcd_inc(cur.min);
        if (wrap_m)
            nxt.hour[5:0] = wrap_h ? 6'h00 : bcd_inc(hour_v)[5:0];
        nxt.hour[CENT_BIT] = cur.hour[CENT_BIT] ^ (wrap_y & cur.hour[CEN_BIT]);
        if (wrap_h) begin
            nxt.wday = (cur.wday == 8'h07) ? 8'h01 : bcd_inc(cur.wday);
            nxt.date = wrap_d ? 8'h01 : bcd_inc(cur.date);
        end
        if (wrap_d)
            nxt.mon = wrap_mo ? 8'h01 : bcd_inc(cur.mon);
        if (wrap_mo)
            nxt.year = wrap_y ? 8'h00 : bcd_inc(cur.year);
    end

endmodule

// File: rtl/serial_rtc_slave.sv
module serial_rtc_slave
    import serial_rtc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sec_tick,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);

    logic              cs_act, rx_valid, rx_first;
    byte_t             rx_byte, rd_data;
    cal_t              tm_q, tm_adv;
    logic              halt_q, tick_pend_q, cmd_wr_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              tx_load, wr_en, adv_req, adv_en;

    serial_rtc_link u_link (
        .clk       (clk),
        .rst       (rst),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .tx_load   (tx_load),
        .tx_data   (rd_data),
        .cs_active (cs_act),
        .rx_valid  (rx_valid),
        .rx_first  (rx_first),
        .rx_byte   (rx_byte),
        .miso      (spi_miso)
    );

    serial_rtc_advance u_adv (
        .cur (tm_q),
        .nxt (tm_adv)
    );

    assign tx_load = rx_valid & rx_first & ~rx_byte[BYTE_W-1];
    assign wr_en   = rx_valid & ~rx_first & cmd_wr_q;
    assign adv_req = ~cs_act & (sec_tick | tick_pend_q);
    assign adv_en  = adv_req & ~tm_q.sec[STOP_BIT] & ~halt_q;

    always_comb begin
        case (ptr_q)
            RA_SEC:  rd_data = tm_q.sec;
            RA_MIN:  rd_data = tm_q.min;
            RA_HOUR: rd_data = tm_q.hour;
            RA_WDAY: rd_data = tm_q.wday;
            RA_DATE: rd_data = tm_q.date;
            RA_MON:  rd_data = tm_q.mon;
            RA_YEAR: rd_data = tm_q.year;
            RA_CTRL: rd_data = byte_t'(halt_q) << HOLD_BIT;
            default: rd_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tm_q        <= CAL_RESET;
            halt_q      <= 1'b1;
            tick_pend_q <= 1'b0;
            cmd_wr_q    <= 1'b0;
            ptr_q       <= '0;
        end else begin
            if (rx_valid) begin
                if (rx_first) begin
                    cmd_wr_q <= rx_byte[BYTE_W-1];
                    ptr_q    <= rx_byte[ADDR_W-1:0];
                end else begin
                    ptr_q <= ptr_q + ADDR_W'(1);
                end
            end

            if (cs_act) begin
                if (sec_tick)
                    tick_pend_q <= 1'b1;
            end else begin
                tick_pend_q <= 1'b0;
            end

            if (wr_en) begin
                case (ptr_q)
                    RA_SEC:  tm_q.sec  <= rx_byte;
                    RA_MIN:  tm_q.min  <= rx_byte;
                    RA_HOUR: tm_q.hour <= rx_byte;
                    RA_WDAY: tm_q.wday <= rx_byte;
                    RA_DATE: tm_q.date <= rx_byte;
                    RA_MON:  tm_q.mon  <= rx_byte;
                    RA_YEAR: tm_q.year <= rx_byte;
                    RA_CTRL: halt_q    <= rx_byte[HOLD_BIT];
                    default: ;
                endcase
            end else if (adv_en) begin
                tm_q <= tm_adv;
            end
        end
    end

endmodule

// File: rtl/serial_rtc_checker.sv
module serial_rtc_checker
    import serial_rtc_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic spi_cs_n,
    input logic spi_miso,
    input logic cs_act,
    input logic wr_en,
    input cal_t tm,
    input logic halt
);

    // R4: three cycles after deselect has been steady, the output is low
    a_r4_miso_idle: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> !spi_miso);

    // R9: a set stop bit freezes every time field outside transfers
    a_r9_stop_freeze: assert property (@(posedge clk) disable iff (rst)
        (tm.sec[STOP_BIT] && !cs_act) |=> $stable(tm));

    // R10: a set hold flag freezes every time field outside transfers
    a_r10_hold_freeze: assert property (@(posedge clk) disable iff (rst)
        (halt && !cs_act) |=> $stable(tm));

    // R11: during a transfer only host writes may change the time
    a_r11_no_advance_selected: assert property (@(posedge clk) disable iff (rst)
        (cs_act && !wr_en) |=> $stable(tm));

endmodule

bind serial_rtc_slave serial_rtc_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .spi_cs_n (spi_cs_n),
    .spi_miso (spi_miso),
    .cs_act   (cs_act),
    .wr_en    (wr_en),
    .tm       (tm_q),
    .halt     (halt_q)
);

// File: tb/serial_rtc_slave_test.sv
module serial_rtc_slave_test;
    import serial_rtc_pkg::*;

    localparam int HALF = 62;   // clk cycles per serial half period, ~1 MHz

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sec_tick = 1'b0;
    logic sclk = 1'b1;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    always #4 clk = ~clk;

    serial_rtc_slave uut (
        .clk      (clk),
        .rst      (rst),
        .sec_tick (sec_tick),
        .spi_sclk (sclk),
        .spi_cs_n (cs_n),
        .spi_mosi (mosi),
        .spi_miso (miso)
    );

    int    checks = 0;
    int    errors = 0;
    byte_t exp_q[$];
    string tag_q[$];
    byte_t got;
    event  got_ev;
    bit    done = 1'b0;

    task automatic check8(input byte_t act, input byte_t exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(got_ev);
            check8(got, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic half_wait();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic xbyte(input byte_t d, output byte_t q, input int ticks_mid);
        q = '0;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            sclk = 1'b0;
            mosi = d[i];
            half_wait();
            q[i] = miso;
            sclk = 1'b1;
            if (i == 4) begin
                for (int k = 0; k < ticks_mid; k++) begin
                    sec_tick = 1'b1;
                    @(negedge clk);
                    sec_tick = 1'b0;
                    @(negedge clk);
                end
            end
            half_wait();
        end
    endtask

    task automatic cs_on();
        @(negedge clk);
        cs_n = 1'b0;
        half_wait();
    endtask

    task automatic cs_off();
        half_wait();
        cs_n = 1'b1;
        repeat (4) half_wait();
    endtask

    task automatic rd(input logic [6:0] a, input byte_t exp, input string tag,
                      input int ticks_mid = 0);
        byte_t dummy, r;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        cs_on();
        xbyte({1'b0, a}, dummy, ticks_mid);
        xbyte(8'h00, r, 0);
        cs_off();
        got = r;
        -> got_ev;
        @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input byte_t d [7], input int n);
        byte_t dummy;
        cs_on();
        xbyte({1'b1, a}, dummy, 0);
        for (int i = 0; i < n; i++)
            xbyte(d[i], dummy, 0);
        cs_off();
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sec_tick = 1'b1;
            @(negedge clk);
            sec_tick = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R4: deselected output low after reset
        check8({7'b0, miso}, 8'h00, "R4 idle after reset");

        // R1 reset values, read through R3 reads
        rd(7'h01, 8'h00, "R1 seconds reset");
        rd(7'h03, 8'h00, "R1 hours reset");
        rd(7'h04, 8'h01, "R1 weekday reset");
        rd(7'h0C, 8'h40, "R1 hold flag reset");

        // R10: hold flag blocks ticks
        tick_n(2);
        rd(7'h01, 8'h00, "R10 seconds frozen while hold set");
        wr(7'h0C, '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, 1);
        rd(7'h0C, 8'h00, "R10 hold flag cleared");
        check8({7'b0, miso}, 8'h00, "R4 idle between transfers");

        // R5: first advance
        tick_n(1);
        rd(7'h01, 8'h01, "R5 seconds 00->01");

        // R2 burst load, R6/R8 full rollover with century enable
        wr(7'h01, '{8'h59, 8'h59, 8'hA3, 8'h07, 8'h31, 8'h12, 8'h99}, 7);
        rd(7'h07, 8'h99, "R2 burst reached year register");
        rd(7'h04, 8'h07, "R2 burst weekday");
        tick_n(1);
        rd(7'h01, 8'h00, "R6 seconds wrap");
        rd(7'h02, 8'h00, "R6 minutes wrap");
        rd(7'h03, 8'hC0, "R8 hour wrap with century toggle");
        rd(7'h04, 8'h01, "R6 weekday 7->1");
        rd(7'h05, 8'h01, "R6 day 31->01");
        rd(7'h06, 8'h01, "R6 month 12->01");
        rd(7'h07, 8'h00, "R6 year 99->00");

        // R8: century enable clear leaves century bit as is
        wr(7'h01, '{8'h59, 8'h59, 8'h63, 8'h03, 8'h31, 8'h12, 8'h99}, 7);
        tick_n(1);
        rd(7'h03, 8'h40, "R8 century bit held without enable");
        rd(7'h07, 8'h00, "R8 year wrap without enable");

        // R7: leap-year February
        wr(7'h01, '{8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24}, 7);
        tick_n(1);
        rd(7'h05, 8'h29, "R7 leap Feb 28->29");
        rd(7'h06, 8'h02, "R7 leap month kept");
        wr(7'h01, '{8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h24}, 7);
        tick_n(1);
        rd(7'h05, 8'h01, "R7 leap Feb 29->Mar 1 day");
        rd(7'h06, 8'h03, "R7 leap Feb 29->Mar 1 month");
        wr(7'h01, '{8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23}, 7);
        tick_n(1);
        rd(7'h05, 8'h01, "R7 common Feb 28->Mar 1 day");
        rd(7'h06, 8'h03, "R7 common Feb 28->Mar 1 month");

        // R9: stop bit
        wr(7'h01, '{8'h89, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, 1);
        tick_n(3);
        rd(7'h01, 8'h89, "R9 seconds frozen while stopped");
        wr(7'h01, '{8'h09, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, 1);
        tick_n(1);
        rd(7'h01, 8'h10, "R9/R5 resume and BCD 09->10");

        // R11: two ticks during a transfer give one deferred step
        rd(7'h01, 8'h10, "R11 no advance while selected", 2);
        rd(7'h01, 8'h11, "R11 single deferred advance");
        check8({7'b0, miso}, 8'h00, "R4 idle at end");

        repeat (10) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule